// File: doc/BRIEF.md
# Multiplexed Stereo DAC Output Stage

This block sits at the end of a time-multiplexed sound channel pipeline. In each output slot it takes one channel's signed 9-bit sample. From that sample it produces the registered left and right words that feed a shared DAC. The channel's two pan bits decide which sides carry the sample. A 2-bit phase inside the 4-cycle subslot decides when the DAC is actually driven. A test-force input can hold the DAC open regardless of phase.

A 2-bit variant select picks one of three output behaviours:

- **Discrete variant.** Non-negative samples are raised by one LSB, which models the zero-crossing step of the resistor ladder. Closed or unpanned periods drive zero.
- **Integrated variant.** The sample passes through unchanged. Closed or unpanned periods drive zero.
- **Legacy variant.** The DAC is open in only one phase of the four. Idle periods drive a small level of plus or minus one, taken from the sample's sign, instead of zero. All values are then scaled by three.

The outputs update on each clock edge while the enable input is high. They hold their value while the enable input is low.

Top module: `tdm_dac_stage`

## Requirements
- R1: While `rst_n` is low, both `left_o` and `right_o` are zero; reset is asynchronous.
- R2: With `en` high, both outputs take the value computed from the inputs sampled at a rising clock edge, visible after that edge; with `en` low they keep their previous value whatever the other inputs do.
- R3: Gate rule. For variant code 2 the DAC is open only when `phase_i` equals 3 or `force_i` is 1. For variant codes 0, 1 and 3 it is open when `phase_i` is not 0 or `force_i` is 1.
- R4: Variant codes 0 and 3 (discrete) apply the same rule to each side. If the side is open with its pan bit at 1, it outputs the sample plus one when the sample is non-negative, and the sample unchanged when it is negative. Otherwise that side outputs 0.
- R5: Variant code 1 (integrated) applies the same rule to each side. If the side is open with its pan bit at 1, it outputs the sample unchanged, sign-extended. Otherwise that side outputs 0.
- R6: Variant code 2 (legacy): a side whose pan bit is 0, or any side while the DAC is closed, outputs +3 for a non-negative sample and -3 for a negative sample.
- R7: Variant code 2 (legacy): a side that is open with its pan bit at 1 outputs 3 × (sample + 1) for a non-negative sample and 3 × sample for a negative sample.
- R8: `left_o` uses only `pan_l_i`, and `right_o` uses only `pan_r_i`. A pan bit of 1 enables its side. The two sides are computed independently from the same sample.
- R9: Outputs are 12-bit two's complement. The extreme values are +768 (legacy, sample 255) and -768 (legacy, sample -256), and neither wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output register update enable |
| smp_i | input | 9 | Signed channel sample |
| pan_l_i | input | 1 | Left side enable (1 = on) |
| pan_r_i | input | 1 | Right side enable (1 = on) |
| phase_i | input | 2 | Position within the 4-cycle subslot |
| force_i | input | 1 | Test input: forces the DAC open |
| variant_i | input | 2 | 0 discrete, 1 integrated, 2 legacy, 3 as discrete |
| left_o | output | 12 | Registered signed left DAC word |
| right_o | output | 12 | Registered signed right DAC word |

## Verification
The assertions check several properties on every cycle:

- Outputs hold while the enable input is low.
- Discrete and integrated outputs are zero in the closed phase or with the pan bit at 0.
- Legacy outputs are never zero and are always multiples of three.
- A closed legacy gate gives exactly plus or minus three.
- Integrated pass-through is exact.

Only the bench's exhaustive sweep over every sample, pan pair, phase, force value and variant can show the exact biased values. The same sweep also shows the sign-level choice at the zero crossing and the ±768 extremes.

// File: rtl/dacp_pkg.sv
package dacp_pkg;

  typedef enum logic [1:0] {
    VAR_DISCRETE = 2'd0,
    VAR_ASIC     = 2'd1,
    VAR_LEGACY   = 2'd2,
    VAR_SPARE    = 2'd3
  } dac_variant_e;

  // DAC open decision for one subslot position
  function automatic logic gate_open(input logic [1:0] v, input logic [1:0] ph,
                                     input logic frc);
    if (v == VAR_LEGACY) return frc | (ph == 2'd3);
    return frc | (ph != 2'd0);
  endfunction

  // Ladder offset applies to every variant except the integrated one
  function automatic logic wants_bias(input logic [1:0] v, input logic neg);
    return (v != VAR_ASIC) && !neg;
  endfunction

endpackage

// File: rtl/dacp_gate.sv
module dacp_gate
  import dacp_pkg::*;
(
  input  logic [1:0] phase_i,
  input  logic       force_i,
  input  logic [1:0] variant_i,
  output logic       open_o,
  output logic       legacy_o
);
  always_comb begin
    open_o   = gate_open(variant_i, phase_i, force_i);
    legacy_o = (variant_i == VAR_LEGACY);
  end
endmodule

// File: rtl/dacp_shape.sv
module dacp_shape
  import dacp_pkg::*;
#(
  parameter int SMP_W = 9
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [1:0]              variant_i,
  output logic signed [SMP_W:0]   active_o,
  output logic signed [SMP_W:0]   idle_o
);
  logic              neg_w;
  logic signed [SMP_W:0] ext_w;
  logic signed [SMP_W:0] bias_w;

  always_comb begin
    neg_w  = smp_i[SMP_W-1];
    ext_w  = {smp_i[SMP_W-1], smp_i};
    bias_w = wants_bias(variant_i, neg_w) ? (SMP_W+1)'(1) : '0;
    active_o = ext_w + bias_w;
    if (variant_i == VAR_LEGACY) idle_o = neg_w ? '1 : (SMP_W+1)'(1);
    else                         idle_o = '0;
  end
endmodule

// File: rtl/dacp_side.sv
module dacp_side #(
  parameter int SMP_W = 9,
  parameter int OUT_W = 12,
  parameter int GAIN  = 3
) (
  input  logic                    pan_i,
  input  logic                    open_i,
  input  logic                    legacy_i,
  input  logic signed [SMP_W:0]   active_i,
  input  logic signed [SMP_W:0]   idle_i,
  output logic signed [OUT_W-1:0] value_o
);
  localparam int EXT_W = OUT_W - SMP_W - 1;
  localparam logic signed [OUT_W-1:0] GAIN_S = OUT_W'(GAIN);

  logic signed [SMP_W:0]   pick_w;
  logic signed [OUT_W-1:0] wide_w;

  always_comb begin
    pick_w  = (pan_i && open_i) ? active_i : idle_i;
    wide_w  = {{EXT_W{pick_w[SMP_W]}}, pick_w};
    value_o = legacy_i ? wide_w * GAIN_S : wide_w;
  end
endmodule

// File: rtl/tdm_dac_stage.sv
module tdm_dac_stage #(
  parameter int SMP_W = 9,
  parameter int OUT_W = 12,
  parameter int GAIN  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    pan_l_i,
  input  logic                    pan_r_i,
  input  logic [1:0]              phase_i,
  input  logic                    force_i,
  input  logic [1:0]              variant_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o
);
  localparam int SIDES = 2;

  logic                    gate_open_w;
  logic                    legacy_w;
  logic signed [SMP_W:0]   active_w;
  logic signed [SMP_W:0]   idle_w;
  logic [SIDES-1:0]        pan_w;
  logic signed [OUT_W-1:0] side_val [SIDES];

  assign pan_w = {pan_r_i, pan_l_i};

  dacp_gate u_gate (
    .phase_i  (phase_i),
    .force_i  (force_i),
    .variant_i(variant_i),
    .open_o   (gate_open_w),
    .legacy_o (legacy_w)
  );

  dacp_shape #(.SMP_W(SMP_W)) u_shape (
    .smp_i    (smp_i),
    .variant_i(variant_i),
    .active_o (active_w),
    .idle_o   (idle_w)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dacp_side #(.SMP_W(SMP_W), .OUT_W(OUT_W), .GAIN(GAIN)) u_side (
      .pan_i   (pan_w[g]),
      .open_i  (gate_open_w),
      .legacy_i(legacy_w),
      .active_i(active_w),
      .idle_i  (idle_w),
      .value_o (side_val[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_o  <= '0;
      right_o <= '0;
    end else if (en) begin
      left_o  <= side_val[0];
      right_o <= side_val[1];
    end
  end
endmodule

// File: rtl/dacp_checker.sv
module dacp_checker #(
  parameter int SMP_W = 9,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic signed [SMP_W-1:0] smp_i,
  input logic                    pan_l_i,
  input logic                    pan_r_i,
  input logic [1:0]              phase_i,
  input logic                    force_i,
  input logic [1:0]              variant_i,
  input logic                    gate_open_w,
  input logic signed [OUT_W-1:0] left_o,
  input logic signed [OUT_W-1:0] right_o
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(left_o) && $stable(right_o)));

  assert_closed_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && variant_i != 2'd2 && phase_i == 2'd0 && !force_i)
      |=> (left_o == '0 && right_o == '0));

  assert_pan_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && variant_i != 2'd2 && !pan_l_i) |=> (left_o == '0));

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && variant_i == 2'd1 && pan_r_i && (phase_i != 2'd0 || force_i))
      |=> (right_o == $past({{(OUT_W-SMP_W){smp_i[SMP_W-1]}}, smp_i})));

  assert_legacy_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && variant_i == 2'd2 && !gate_open_w)
      |=> ((left_o == 12'sd3 || left_o == -12'sd3) &&
           (right_o == 12'sd3 || right_o == -12'sd3)));

  assert_legacy_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && variant_i == 2'd2)
      |=> (left_o != '0 && right_o != '0 && (left_o % 3) == 0 && (right_o % 3) == 0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (left_o <= 12'sd768 && left_o >= -12'sd768 &&
     right_o <= 12'sd768 && right_o >= -12'sd768));
endmodule

bind tdm_dac_stage dacp_checker #(.SMP_W(SMP_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/sim_tdm_dac_stage.sv
module sim_tdm_dac_stage;
  typedef struct {
    int    l;
    int    r;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic signed [8:0] smp = '0;
  logic              pl = 1'b0, pr = 1'b0, frc = 1'b0;
  logic [1:0]        ph = '0, var_sel = '0;
  logic signed [11:0] lo, ro;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  int   last_l = 0, last_r = 0;

  always #5 clk = ~clk;

  tdm_dac_stage u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_i(smp),
    .pan_l_i(pl), .pan_r_i(pr), .phase_i(ph), .force_i(frc),
    .variant_i(var_sel), .left_o(lo), .right_o(ro)
  );

  // Reference model written from the requirements
  function automatic int model(int s, bit pan, int p, bit f, int v);
    bit on;
    if (v == 2) begin
      on = f || (p == 3);
      if (pan && on) return 3 * ((s >= 0) ? s + 1 : s);  // R7
      return (s >= 0) ? 3 : -3;                          // R6
    end
    on = f || (p != 0);
    if (!(pan && on)) return 0;
    if (v == 1) return s;                                // R5
    return (s >= 0) ? s + 1 : s;                         // R4
  endfunction

  function automatic string tag_of(bit e, int v, bit p_on);
    if (!e) return "R2";
    if (v == 2) return p_on ? "R3 R7 R8" : "R3 R6 R8";
    if (v == 1) return "R3 R5 R8";
    return "R3 R4 R8";
  endfunction

  task automatic drive(int s, bit a, bit b, int p, bit f, int v, bit e, string force_tag);
    exp_t it;
    @(negedge clk);
    smp = 9'(s); pl = a; pr = b; ph = 2'(p); frc = f; var_sel = 2'(v); en = e;
    if (e) begin
      last_l = model(s, a, p, f, v);
      last_r = model(s, b, p, f, v);
    end
    it.l = last_l;
    it.r = last_r;
    it.tag = (force_tag != "") ? force_tag : tag_of(e, v, a | b);
    sb.push_back(it);
  endtask

  // Monitor: one result per clock edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (int'(lo) != it.l || int'(ro) != it.r) begin
          fails++;
          $display("FAIL %s: left=%0d right=%0d expected left=%0d right=%0d",
                   it.tag, lo, ro, it.l, it.r);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset holds outputs at zero even with active inputs
    en = 1'b1; smp = 9'sd100; pl = 1'b1; pr = 1'b1; ph = 2'd3; var_sel = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (lo != 0 || ro != 0) begin
      fails++;
      $display("FAIL R1: left=%0d right=%0d expected left=0 right=0", lo, ro);
    end
    rst_n = 1'b1;

    // Exhaustive sweep; every seventh vector has en low (R2)
    n = 0;
    for (int v = 0; v < 4; v++)
      for (int s = -256; s < 256; s++)
        for (int pan = 0; pan < 4; pan++)
          for (int p = 0; p < 4; p++)
            for (int f = 0; f < 2; f++) begin
              drive(s, pan[0], pan[1], p, f[0], v, (n % 7) != 6, "");
              n++;
            end

    // R9: extremes of the legacy scale on both sides
    drive(255, 1'b1, 1'b1, 3, 1'b0, 2, 1'b1, "R9");
    drive(-256, 1'b1, 1'b1, 3, 1'b0, 2, 1'b1, "R9");
    // R8: opposite pans on the two sides
    drive(-5, 1'b1, 1'b0, 1, 1'b0, 0, 1'b1, "R8");
    drive(7, 1'b0, 1'b1, 3, 1'b0, 2, 1'b1, "R8");
    // R2: en low holds the value across changed inputs
    drive(40, 1'b1, 1'b1, 2, 1'b0, 1, 1'b0, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule